// File: doc/BRIEF.md
# CAN Transceiver Mode Controller

This block is the synchronous control core of a high-speed CAN physical-layer transceiver. It samples the transmit pin from the protocol controller and a silent-select pin. It also watches three flags: undervoltage on the core rail, undervoltage on the I/O rail, and overtemperature. From these it decides whether the bus driver may pull the bus dominant, whether the bus bias is on, and what the receive pin shows. The analog front end (slope shaping, bias network, current limit, receive comparator) lives outside the block and is seen only through single-bit flags.

Three operating states exist. In Normal the node both transmits and receives. In Silent the node only listens. In Off, which is forced by an undervoltage on either rail, the bias is removed and the receive pin is released. A dominant-period watchdog limits how long a stuck-low transmit pin can hold the bus. A lock register keeps the driver off after a watchdog expiry, an overtemperature event or an undervoltage episode, and lifts only once the fault has cleared and the transmit pin has been seen high.

Top module: `canx_mode_ctl`

## Requirements
- R1: In Normal, `txDrive` is 1 while the synchronized transmit pin is 0 and no lock is active, and 0 while it is 1. A change on `txdIn` reaches `txDrive` after two clock edges.
- R2: With `silentIn` high the block enters Silent three edges later. `txDrive` then stays 0 whatever `txdIn` does, while `biasEn` stays 1.
- R3: Whenever `rxdOe` is 1 (Normal or Silent), `rxdOut` is the inverse of `rxCompDom` (1 = bus dominant), including dominant levels caused by other nodes.
- R4: `uvCore` or `uvIo` high at a clock edge puts the block in Off from the next cycle. In Off, `biasEn`, `rxdOe` and `txDrive` are all 0.
- R5: Off is left only at an edge where both `uvCore` and `uvIo` are low. The next state is Silent if the synchronized `silentIn` is high, otherwise Normal.
- R6: `txDrive` can stay 1 for at most `TIMEOUT_CYC` consecutive cycles. A return of the transmit pin to high restarts the count, so lows shorter than the limit are driven in full.
- R7: After a timeout expiry, `txDrive` stays 0 while `txdIn` stays low. It becomes possible again only after the synchronized pin has been high.
- R8: `overTemp` high forces `txDrive` to 0 in the same cycle, while bias and reception continue. Once it clears, driving resumes only after the transmit pin has been seen high.
- R9: After leaving Off, no dominant is driven until the synchronized transmit pin has been high at least once.
- R10: During and right after reset the block is in Off. The synchronizers reset to 1, modelling the pull-ups, so the first state after reset is Silent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| txdIn | input | 1 | Transmit pin from the controller, 0 = dominant request |
| silentIn | input | 1 | Listen-only select, 1 = Silent |
| uvCore | input | 1 | Core rail undervoltage flag |
| uvIo | input | 1 | I/O rail undervoltage flag |
| overTemp | input | 1 | Junction overtemperature flag |
| rxCompDom | input | 1 | Sampled receive comparator, 1 = bus dominant |
| txDrive | output | 1 | Driver enable: 1 = drive the bus dominant |
| biasEn | output | 1 | Bus bias enable |
| rxdOut | output | 1 | Receive pin level, 0 = dominant |
| rxdOe | output | 1 | Receive pin output enable, 0 = high-impedance |

## Verification
The dominant-period watchdog and the release of the transmit pin can act in the same cycle. When the pin is raised so that its synchronized rise arrives exactly at the cycle where the count reaches its limit, expiry and restart coincide. The bench times the release for that cycle. It then requires that the bus had been driven for exactly the full window, that the driver is off in that cycle, and that a fresh low a few cycles later is driven again, so the lock has not stuck. The same holds when the driver is already off for overtemperature or undervoltage and the pin is released while the fault flag falls.

// File: rtl/canx_pkg.sv
package canx_pkg;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_NORMAL = 2'd1,
    MODE_SILENT = 2'd2
  } canxMode_t;

  // datapath -> control
  typedef struct packed {
    logic txLow;       // synchronized transmit pin is low
    logic domTimeout;  // dominant window used up
    logic silentSel;   // synchronized silent select
  } canxPinStat_t;

  // control -> datapath
  typedef struct packed {
    logic timerClr;    // hold timer at zero (Off state)
  } canxCtrlStb_t;

endpackage

// File: rtl/canx_datapath.sv
module canx_datapath
  import canx_pkg::*;
#(
  parameter int TIMEOUT_CYC = 2940,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         txdIn,
  input  logic         silentIn,
  input  canxCtrlStb_t stb,
  output canxPinStat_t stat
);

  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TIMEOUT_CYC);

  logic [SYNC_STAGES-1:0] txSh;
  logic [SYNC_STAGES-1:0] selSh;
  logic [CNT_W-1:0]       domCnt;
  logic                   txSync;

  // pull-up behaviour: synchronizers come out of reset at 1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh  <= '1;
      selSh <= '1;
    end else begin
      txSh  <= {txSh[SYNC_STAGES-2:0], txdIn};
      selSh <= {selSh[SYNC_STAGES-2:0], silentIn};
    end
  end

  assign txSync = txSh[SYNC_STAGES-1];

  // counts cycles of synchronized low; any high (rising edge) restarts it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      domCnt <= '0;
    end else if (stb.timerClr || txSync) begin
      domCnt <= '0;
    end else if (domCnt != CNT_MAX) begin
      domCnt <= domCnt + 1'b1;
    end
  end

  always_comb begin
    stat.txLow      = ~txSync;
    stat.domTimeout = (domCnt == CNT_MAX);
    stat.silentSel  = selSh[SYNC_STAGES-1];
  end

endmodule

// File: rtl/canx_ctrl.sv
module canx_ctrl
  import canx_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         uvAny,
  input  logic         overTemp,
  input  canxPinStat_t stat,
  output canxCtrlStb_t stb,
  output canxMode_t    mode,
  output logic         txDrive
);

  canxMode_t modeQ;
  logic      txLockQ;
  logic      lockSet;
  logic      lockClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_OFF;
    end else if (uvAny) begin
      modeQ <= MODE_OFF;
    end else if (stat.silentSel) begin
      modeQ <= MODE_SILENT;
    end else begin
      modeQ <= MODE_NORMAL;
    end
  end

  assign lockSet = (modeQ == MODE_OFF) | stat.domTimeout | overTemp;
  assign lockClr = ~stat.txLow;

  // lock starts set: power-up counts as leaving undervoltage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txLockQ <= 1'b1;
    end else if (lockSet) begin
      txLockQ <= 1'b1;
    end else if (lockClr) begin
      txLockQ <= 1'b0;
    end
  end

  assign stb.timerClr = (modeQ == MODE_OFF);
  assign mode         = modeQ;
  assign txDrive      = (modeQ == MODE_NORMAL) & ~txLockQ & stat.txLow
                        & ~stat.domTimeout & ~overTemp;

endmodule

// File: rtl/canx_mode_ctl.sv
module canx_mode_ctl
  import canx_pkg::*;
#(
  parameter int TIMEOUT_CYC = 2940,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic txdIn,
  input  logic silentIn,
  input  logic uvCore,
  input  logic uvIo,
  input  logic overTemp,
  input  logic rxCompDom,
  output logic txDrive,
  output logic biasEn,
  output logic rxdOut,
  output logic rxdOe
);

  canxPinStat_t pinStat;
  canxCtrlStb_t ctrlStb;
  canxMode_t    modeQ;
  logic         powered;

  canx_datapath #(
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .txdIn    (txdIn),
    .silentIn (silentIn),
    .stb      (ctrlStb),
    .stat     (pinStat)
  );

  canx_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .uvAny    (uvCore | uvIo),
    .overTemp (overTemp),
    .stat     (pinStat),
    .stb      (ctrlStb),
    .mode     (modeQ),
    .txDrive  (txDrive)
  );

  assign powered = (modeQ != MODE_OFF);
  assign biasEn  = powered;
  assign rxdOe   = powered;
  assign rxdOut  = powered ? ~rxCompDom : 1'b1;

endmodule

// File: rtl/canx_mode_chk.sv
module canx_mode_chk
  import canx_pkg::*;
#(
  parameter int TIMEOUT_CYC = 2940
) (
  input logic      clk,
  input logic      rstN,
  input logic      txdIn,
  input logic      uvCore,
  input logic      uvIo,
  input logic      overTemp,
  input logic      txDrive,
  input logic      biasEn,
  input logic      rxdOe,
  input canxMode_t mode
);

  localparam int RUN_W = $clog2(TIMEOUT_CYC + 2);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(TIMEOUT_CYC + 1);

  logic [RUN_W-1:0] domRun;  // preceding consecutive driven cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) domRun <= '0;
    else if (!txDrive) domRun <= '0;
    else if (domRun != RUN_MAX) domRun <= domRun + 1'b1;
  end

  a_r1_drive_needs_low_pin: assert property (@(posedge clk) disable iff (!rstN)
    txDrive |-> !$past(txdIn, 2));

  a_r4_uv_enters_off: assert property (@(posedge clk) disable iff (!rstN)
    (uvCore || uvIo) |=> (!biasEn && !rxdOe && !txDrive));

  a_r5_off_held_under_uv: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_OFF && (uvCore || uvIo)) |=> mode == MODE_OFF);

  a_r6_dom_window_bounded: assert property (@(posedge clk) disable iff (!rstN)
    txDrive |-> (domRun < RUN_W'(TIMEOUT_CYC)));

  a_r8_hot_blocks_drive: assert property (@(posedge clk) disable iff (!rstN)
    overTemp |-> !txDrive);

  a_r9_no_drive_leaving_off: assert property (@(posedge clk) disable iff (!rstN)
    $past(mode == MODE_OFF) |-> !txDrive);

endmodule

bind canx_mode_ctl canx_mode_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .txdIn    (txdIn),
  .uvCore   (uvCore),
  .uvIo     (uvIo),
  .overTemp (overTemp),
  .txDrive  (txDrive),
  .biasEn   (biasEn),
  .rxdOe    (rxdOe),
  .mode     (modeQ)
);

// File: tb/canx_mode_ctl_tb_top.sv
`timescale 1ns/1ps
module canx_mode_ctl_tb_top;

  localparam int LIM = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txdIn = 1'b1;
  logic silentIn = 1'b1;
  logic uvCore = 1'b0;
  logic uvIo = 1'b0;
  logic overTemp = 1'b0;
  logic rxCompDom = 1'b0;
  logic txDrive, biasEn, rxdOut, rxdOe;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  canx_mode_ctl #(.TIMEOUT_CYC(LIM)) dut_i (
    .clk(clk), .rstN(rstN), .txdIn(txdIn), .silentIn(silentIn),
    .uvCore(uvCore), .uvIo(uvIo), .overTemp(overTemp), .rxCompDom(rxCompDom),
    .txDrive(txDrive), .biasEn(biasEn), .rxdOut(rxdOut), .rxdOe(rxdOe)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // bring to Normal with pin high and lock cleared
  task automatic goNormal();
    txdIn = 1'b1; silentIn = 1'b0;
    step(5);
  endtask

  task automatic tReset();
    step(1);
    chk("R10", "bias in reset", biasEn, 1'b0);
    chk("R10", "rxOe in reset", rxdOe, 1'b0);
    rstN = 1'b1;
    step(1);
    chk("R10", "silent after reset bias", biasEn, 1'b1);
    txdIn = 1'b0;
    step(3);
    chk("R10", "silent after reset no drive", txDrive, 1'b0);
    txdIn = 1'b1;
    step(3);
  endtask

  task automatic tNormal();
    goNormal();
    chk("R1", "recessive idle", txDrive, 1'b0);
    txdIn = 1'b0;
    step(1);
    chk("R1", "one edge not yet", txDrive, 1'b0);
    step(1);
    chk("R1", "dominant after two", txDrive, 1'b1);
    txdIn = 1'b1;
    step(2);
    chk("R1", "recessive again", txDrive, 1'b0);
  endtask

  task automatic tRx();
    rxCompDom = 1'b1; #1;
    chk("R3", "rx dominant normal", rxdOut, 1'b0);
    rxCompDom = 1'b0; #1;
    chk("R3", "rx recessive normal", rxdOut, 1'b1);
  endtask

  task automatic tSilent();
    silentIn = 1'b1;
    step(3);
    txdIn = 1'b0;
    step(3);
    chk("R2", "silent no drive", txDrive, 1'b0);
    chk("R2", "silent bias kept", biasEn, 1'b1);
    rxCompDom = 1'b1; #1;
    chk("R3", "rx dominant silent", rxdOut, 1'b0);
    rxCompDom = 1'b0;
    txdIn = 1'b1;
    goNormal();
  endtask

  task automatic tTimeout();
    goNormal();
    txdIn = 1'b0;
    step(LIM + 1);
    chk("R6", "last driven cycle", txDrive, 1'b1);
    step(1);
    chk("R6", "window expired", txDrive, 1'b0);
    step(10);
    chk("R7", "held low stays off", txDrive, 1'b0);
    txdIn = 1'b1;
    step(4);
    txdIn = 1'b0;
    step(2);
    chk("R7", "drive after release", txDrive, 1'b1);
    txdIn = 1'b1;
    step(3);
  endtask

  task automatic tShortPulses();
    goNormal();
    for (int k = 0; k < 4; k++) begin
      txdIn = 1'b0;
      step(LIM - 2);
      chk("R6", "short low still driven", txDrive, 1'b1);
      txdIn = 1'b1;
      step(1);
    end
    step(3);
  endtask

  task automatic tCoincide();
    goNormal();
    txdIn = 1'b0;
    repeat (LIM) @(negedge clk);
    txdIn = 1'b1;
    @(negedge clk);
    chk("R6", "coincide last driven", txDrive, 1'b1);
    @(negedge clk);
    chk("R6", "coincide expiry off", txDrive, 1'b0);
    step(3);
    txdIn = 1'b0;
    step(2);
    chk("R7", "coincide no stuck lock", txDrive, 1'b1);
    txdIn = 1'b1;
    step(3);
  endtask

  task automatic tOverTemp();
    goNormal();
    txdIn = 1'b0;
    step(2);
    chk("R8", "driving before hot", txDrive, 1'b1);
    overTemp = 1'b1; #1;
    chk("R8", "hot cuts drive", txDrive, 1'b0);
    chk("R8", "hot keeps bias", biasEn, 1'b1);
    rxCompDom = 1'b1; #1;
    chk("R8", "hot keeps rx", rxdOut, 1'b0);
    rxCompDom = 1'b0;
    step(1);
    overTemp = 1'b0;
    step(3);
    chk("R8", "cool but pin low", txDrive, 1'b0);
    txdIn = 1'b1;
    step(4);
    txdIn = 1'b0;
    step(2);
    chk("R8", "drive after cool and release", txDrive, 1'b1);
    txdIn = 1'b1;
    step(3);
  endtask

  task automatic tUndervolt();
    goNormal();
    txdIn = 1'b0;
    step(2);
    uvCore = 1'b1;
    step(1);
    chk("R4", "uv bias off", biasEn, 1'b0);
    chk("R4", "uv rx released", rxdOe, 1'b0);
    chk("R4", "uv drive off", txDrive, 1'b0);
    uvCore = 1'b0;
    step(1);
    chk("R5", "leave off to normal", biasEn, 1'b1);
    step(3);
    chk("R9", "pin still low no drive", txDrive, 1'b0);
    txdIn = 1'b1;
    step(4);
    txdIn = 1'b0;
    step(2);
    chk("R9", "drive after release", txDrive, 1'b1);
    txdIn = 1'b1;
    step(3);
  endtask

  task automatic tUvBoth();
    goNormal();
    uvCore = 1'b1; uvIo = 1'b1;
    step(2);
    uvCore = 1'b0;
    step(2);
    chk("R5", "io rail still low keeps off", biasEn, 1'b0);
    silentIn = 1'b1;
    step(4);
    uvIo = 1'b0;
    step(1);
    chk("R5", "exit powered", biasEn, 1'b1);
    txdIn = 1'b0;
    step(6);
    chk("R5", "exit into silent", txDrive, 1'b0);
    txdIn = 1'b1;
    goNormal();
  endtask

  initial begin
    tReset();
    tNormal();
    tRx();
    tSilent();
    tTimeout();
    tShortPulses();
    tCoincide();
    tOverTemp();
    tUndervolt();
    tUvBoth();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule